// File: doc/BRIEF.md
# Match-Compare System Timer with Watchdog Channel

This block is a memory-mapped system timer. A single 32-bit up-counter moves forward by one on every cycle in which the external tick enable is high. Four 32-bit compare registers are checked against the value the counter is about to take. On a tick where the counter becomes equal to a compare value, that channel's pending bit and its interrupt line go high, provided the channel's interrupt enable is set. Software clears pending bits by writing ones to the status register. Only bits that are both written as one and currently pending are cleared.

Channel 3 also serves as a one-shot watchdog. While the arm bit is set, a channel 3 compare hit produces a one-cycle reset-request pulse and clears the arm bit. This happens whatever the channel's interrupt enable is. Software reaches the registers through a simple single-cycle read/write port. Read data and the access-error flag are registered and appear one cycle after the request.

Top module: `os_match_timer`

## Requirements
- R1: After reset the counter, all compare values, the interrupt enables, the status bits and the watchdog arm bit read as zero, and irq and rst_req are low.
- R2: The counter adds one on each cycle with tick high and wraps from 0xFFFFFFFF to 0. A write to offset 0x10 loads the counter, takes priority over a tick in the same cycle, and counting continues from the loaded value.
- R3: Compare registers sit at offsets 0x00, 0x04, 0x08 and 0x0C for channels 0 to 3. A hit happens on the tick where the counter takes the compare value. With enable bit k set, a hit on channel k sets status bit k and irq[k], and both then stay high until cleared.
- R4: A hit on channel k while enable bit k is 0 leaves status bit k and irq[k] unchanged.
- R5: A write to the status register at offset 0x14 clears exactly the bits that are written as 1 and are currently set. The matching irq lines go low. Bits written as 0 keep their value.
- R6: The interrupt-enable register at offset 0x1C stores bits 11:0 of a write and reads bits 31:12 as zero. Bit k (k < 4) enables channel k.
- R7: The watchdog arm register at offset 0x18 keeps bit 0 only. A channel 3 hit while bit 0 is 1 drives rst_req high for exactly one cycle and clears bit 0, independent of enable bit 3. A further hit with bit 0 clear gives no pulse.
- R8: A read with rd_en high returns the addressed register on rdata in the next cycle. The counter reads as its value before that clock edge.
- R9: A read or write to any offset outside 0x00–0x1C returns zero on rdata and raises err for one cycle. Such a write changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Counter advance enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| err | output | 1 | One-cycle flag for an access to an undefined offset |
| irq | output | 4 | Per-channel level interrupt, equal to the pending bits |
| rst_req | output | 1 | One-cycle system reset request from the watchdog channel |

## Verification
A wrong counter step or a lost load shows up as a wrong count read back right after a few ticks. It also shows as a compare hit that comes one tick early, one tick late, or never. A wrong pending or enable state is seen on irq at the negative edge after the tick edge concerned, and on the status read one cycle later. A stuck or badly cleared watchdog arm bit shows as a missing, repeated or stretched rst_req pulse in the cycle after the channel 3 hit, and as a nonzero arm read.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;
    localparam int CNT_W  = 32;
    localparam int NUM_CH = 4;
    localparam int IE_W   = 12;
    localparam int ADDR_W = 8;
    localparam int WD_CH  = NUM_CH - 1;

    localparam logic [ADDR_W-1:0] OFF_COUNT = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_PEND  = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_ARM   = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_ENA   = 8'h1C;

    typedef struct packed {
        logic [NUM_CH-1:0] raw;
        logic [NUM_CH-1:0] gated;
    } hit_vec_t;

    function automatic logic [ADDR_W-1:0] cmp_off(input int idx);
        return ADDR_W'(4 * idx);
    endfunction
endpackage

// File: rtl/ostmr_counter.sv
module ostmr_counter
    import ostmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic [W-1:0] count_next,
    output logic         step
);
    assign step       = tick & ~load;
    assign count_next = count + W'(1);

    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (load) count <= load_val;
        else if (tick) count <= count_next;
    end
endmodule

// File: rtl/ostmr_channel.sv
module ostmr_channel
    import ostmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wval,
    input  logic         step,
    input  logic [W-1:0] count_next,
    input  logic         enable,
    output logic [W-1:0] cmp_val,
    output logic         raw_hit,
    output logic         hit
);
    always_ff @(posedge clk) begin
        if (rst)     cmp_val <= '0;
        else if (wr) cmp_val <= wval;
    end

    assign raw_hit = step & (count_next == cmp_val);
    assign hit     = raw_hit & enable;
endmodule

// File: rtl/os_match_timer.sv
module os_match_timer
    import ostmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              err,
    output logic [NUM_CH-1:0] irq,
    output logic              rst_req
);
    logic [CNT_W-1:0]  count, count_next;
    logic              step;
    logic [CNT_W-1:0]  cmp_val [NUM_CH];
    hit_vec_t          hits;
    logic [NUM_CH-1:0] pend_q;
    logic [IE_W-1:0]   ena_q;
    logic              arm_q;
    logic              fire;
    logic              wr_count, wr_pend, wr_arm, wr_ena;
    logic [CNT_W-1:0]  rd_val;
    logic              addr_ok;
    logic [NUM_CH-1:0] clr_mask;

    assign wr_count = wr_en & (addr == OFF_COUNT);
    assign wr_pend  = wr_en & (addr == OFF_PEND);
    assign wr_arm   = wr_en & (addr == OFF_ARM);
    assign wr_ena   = wr_en & (addr == OFF_ENA);

    ostmr_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .load(wr_count), .load_val(wdata),
        .count(count), .count_next(count_next), .step(step)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        ostmr_channel #(.W(CNT_W)) u_ch (
            .clk(clk), .rst(rst),
            .wr(wr_en & (addr == cmp_off(k))), .wval(wdata),
            .step(step), .count_next(count_next), .enable(ena_q[k]),
            .cmp_val(cmp_val[k]), .raw_hit(hits.raw[k]), .hit(hits.gated[k])
        );
    end

    assign clr_mask = wr_pend ? (wdata[NUM_CH-1:0] & pend_q) : '0;
    assign fire     = hits.raw[WD_CH] & arm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            ena_q   <= '0;
            arm_q   <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            pend_q  <= (pend_q & ~clr_mask) | hits.gated;
            rst_req <= fire;
            if (wr_ena) ena_q <= wdata[IE_W-1:0];
            if (fire)        arm_q <= 1'b0;
            else if (wr_arm) arm_q <= wdata[0];
        end
    end

    assign irq = pend_q;

    always_comb begin
        rd_val  = '0;
        addr_ok = 1'b0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (addr == cmp_off(k)) begin
                rd_val  = cmp_val[k];
                addr_ok = 1'b1;
            end
        end
        case (addr)
            OFF_COUNT: begin rd_val = count;                addr_ok = 1'b1; end
            OFF_PEND:  begin rd_val = CNT_W'(pend_q);       addr_ok = 1'b1; end
            OFF_ARM:   begin rd_val = CNT_W'(arm_q);        addr_ok = 1'b1; end
            OFF_ENA:   begin rd_val = CNT_W'(ena_q);        addr_ok = 1'b1; end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            rdata <= rd_en ? rd_val : '0;
            err   <= (rd_en | wr_en) & ~addr_ok;
        end
    end
endmodule

// File: rtl/ostmr_checker.sv
module ostmr_checker
    import ostmr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [CNT_W-1:0]  rdata,
    input logic              err,
    input logic [NUM_CH-1:0] irq,
    input logic              rst_req,
    input logic [CNT_W-1:0]  count,
    input logic [IE_W-1:0]   ena_q,
    input logic              arm_q
);
    p_rstreq_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    p_arm_cleared_r7: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> !arm_q);

    p_err_reads_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (err && $past(rd_en)) |-> (rdata == '0));

    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(tick) && !$past(wr_en && addr == OFF_COUNT))
        |-> (count == $past(count) + CNT_W'(1)));

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
        p_irq_needs_enable_r4: assert property (@(posedge clk) disable iff (rst)
            $rose(irq[k]) |-> $past(ena_q[k]));
        p_irq_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
            $rose(irq[k]) |-> $past(tick));
    end
endmodule

bind os_match_timer ostmr_checker u_ostmr_checker (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .rdata(rdata), .err(err), .irq(irq), .rst_req(rst_req),
    .count(count), .ena_q(ena_q), .arm_q(arm_q)
);

// File: tb/tb_os_match_timer.sv
module tb_os_match_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err;
    logic [3:0]  irq;
    logic        rst_req;

    int n_chk = 0;
    int n_fail = 0;
    int n_pulse = 0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    os_match_timer dut (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .err(err),
        .irq(irq), .rst_req(rst_req)
    );

    always @(negedge clk) if (rst_req) n_pulse++;

    // op: 0 write, 1 read and compare, 2 read expecting err
    localparam int NV = 14;
    localparam logic [73:0] VEC [NV] = '{
        {2'd1, 8'h00, 32'h0, 32'h0000_0000},
        {2'd1, 8'h10, 32'h0, 32'h0000_0000},
        {2'd0, 8'h00, 32'h0000_0005, 32'h0},
        {2'd0, 8'h0C, 32'hCAFE_0003, 32'h0},
        {2'd1, 8'h00, 32'h0, 32'h0000_0005},
        {2'd1, 8'h0C, 32'h0, 32'hCAFE_0003},
        {2'd0, 8'h1C, 32'hFFFF_FFFF, 32'h0},
        {2'd1, 8'h1C, 32'h0, 32'h0000_0FFF},
        {2'd0, 8'h18, 32'hFFFF_FFFF, 32'h0},
        {2'd1, 8'h18, 32'h0, 32'h0000_0001},
        {2'd0, 8'h10, 32'h0000_0064, 32'h0},
        {2'd1, 8'h10, 32'h0, 32'h0000_0064},
        {2'd2, 8'h24, 32'h0, 32'h0000_0000},
        {2'd2, 8'h40, 32'h0, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 irq", {28'h0, irq}, 32'h0);
        check("R1 rst_req", {31'h0, rst_req}, 32'h0);
        rd(8'h14, rv); check("R1 status", rv, 32'h0);
        rd(8'h1C, rv); check("R1 enable", rv, 32'h0);

        // Table walk: R8 map and latency, R6 enable width, R7 arm width, R9 bad offsets
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [7:0]  a;
            logic [31:0] d, e;
            {op, a, d, e} = VEC[i];
            if (op == 2'd0) wr(a, d);
            else begin
                rd(a, rv);
                check(op == 2'd2 ? "R9 bad read data" : "R8 R6 R7 readback", rv, e);
                if (op == 2'd2) check("R9 err flag", {31'h0, err}, 32'h1);
            end
        end

        // R9: bad write changes nothing and flags err
        wr(8'h30, 32'h1234_5678);
        check("R9 err on write", {31'h0, err}, 32'h1);
        rd(8'h00, rv); check("R9 no side effect", rv, 32'h5);

        // R2: load then count
        wr(8'h18, 32'h0);
        wr(8'h1C, 32'h0);
        wr(8'h10, 32'd10);
        ticks(3);
        rd(8'h10, rv); check("R2 count after load", rv, 32'd13);

        // R3: hit on tick where count becomes equal
        wr(8'h1C, 32'h1);
        wr(8'h00, 32'd20);
        wr(8'h10, 32'd18);
        ticks(1);
        check("R3 no early irq", {28'h0, irq}, 32'h0);
        ticks(1);
        check("R3 irq0 on hit", {28'h0, irq}, 32'h1);
        ticks(2);
        check("R3 irq level holds", {28'h0, irq}, 32'h1);
        rd(8'h14, rv); check("R3 status", rv, 32'h1);

        // R4: disabled channel ignored
        wr(8'h04, 32'd25);
        wr(8'h10, 32'd24);
        ticks(1);
        check("R4 irq1 stays low", {28'h0, irq}, 32'h1);
        rd(8'h14, rv); check("R4 status bit1 clear", rv, 32'h1);

        // R5: write-one-to-clear
        wr(8'h14, 32'hE);
        check("R5 unset bits no effect", {28'h0, irq}, 32'h1);
        wr(8'h14, 32'h1);
        check("R5 irq0 cleared", {28'h0, irq}, 32'h0);
        rd(8'h14, rv); check("R5 status cleared", rv, 32'h0);

        // R2 wrap with R3 hit at zero
        wr(8'h1C, 32'h4);
        wr(8'h08, 32'h0);
        wr(8'h10, 32'hFFFF_FFFF);
        ticks(1);
        check("R2 wrap hit ch2", {28'h0, irq}, 32'h4);
        rd(8'h10, rv); check("R2 wrapped count", rv, 32'h0);
        wr(8'h14, 32'h4);

        // R2: load wins over simultaneous tick
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; addr = 8'h10; wdata = 32'd500;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        rd(8'h10, rv); check("R2 load priority", rv, 32'd500);

        // R7: watchdog, enable bit 3 clear
        wr(8'h1C, 32'h0);
        wr(8'h18, 32'h1);
        wr(8'h0C, 32'd1002);
        wr(8'h10, 32'd1000);
        ticks(1);
        check("R7 no early pulse", {31'h0, rst_req}, 32'h0);
        ticks(1);
        check("R7 pulse on hit", {31'h0, rst_req}, 32'h1);
        @(negedge clk);
        check("R7 pulse one cycle", {31'h0, rst_req}, 32'h0);
        check("R7 no irq3 when disabled", {28'h0, irq}, 32'h0);
        rd(8'h18, rv); check("R7 arm self-cleared", rv, 32'h0);
        wr(8'h10, 32'd1000);
        ticks(3);
        check("R7 single pulse total", n_pulse, 32'd1);

        // R1: reset mid-run
        wr(8'h1C, 32'h1);
        wr(8'h00, 32'd2000);
        wr(8'h10, 32'd1999);
        ticks(1);
        check("R1 pre-reset irq", {28'h0, irq}, 32'h1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        check("R1 irq after reset", {28'h0, irq}, 32'h0);
        rd(8'h00, rv); check("R1 compare after reset", rv, 32'h0);
        rd(8'h10, rv); check("R1 count after reset", rv, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule